// File: doc/BRIEF.md
# USB OTG Dual-Role Host Swap Controller

This block sequences the exchange of the host role between the two ends of an On-The-Go link. It works on decoded line events (idle, disconnect, connect, resume) and does not see packets. A strap input picks the A-device side or the B-device side. The controller then drives the D+ and D- pull-up controls, the VBUS supply enable and the host/peripheral role flag. It also issues one-cycle requests for bus reset and resume signaling to the transceiver logic. A built-in idle timer flags suspend once the line has been idle for three milliseconds without a break.

A session-level decoder reads external VBUS comparator pins. It accepts either a two-pin encoding or a three-pin encoding, chosen by a select input. The decoded level gates session start on the B side. A fall of VBUS below the session-end threshold sends either side back to the unattached state, with every pull-up released and the supply off.

Top module: `otg_role_swap`

## Requirements
- R1: While reset is held and right after it, every output is 0: pull-ups off, no reset or resume request, VBUS off, peripheral role, suspend low, session level 0, error flag low.
- R2: With cmp_sel_i = 0 the level is decoded from cmp_pins_i[1:0], where bit 1 is the first comparator and bit 0 the second. 00 gives level 0 (below session-end), 10 gives 1 (between session-end and session-valid), 01 gives 2 (between session-valid and VBUS-valid) and 11 gives 3 (above VBUS-valid). The level register updates one clock after the pins change.
- R3: With cmp_sel_i = 1, cmp_pins_i[2:0] = {vbus_valid, sess_valid, sess_end} decodes 001 to level 0, 000 to 1, 010 to 2 and 110 to 3. Any other pattern holds the previous level and sets cmp_err_o for as long as it lasts.
- R4: suspend_o rises after 3*CLK_PER_MS consecutive clocks with line_idle_i high, and not one clock earlier. Any clock with line_idle_i low clears it and restarts the count.
- R5: A B-device (a_role_i = 0) in the unattached state moves to peripheral once the session level is 2 or more. At full speed it drives dp_pu_o; at low speed it drives dm_pu_o instead.
- R6: A B-device peripheral releases both pull-ups to ask for the host role only when all of these hold: b_req_host_i is high, hnp_en_i is high, full_speed_i is high and the link is suspended. Otherwise the pull-up stays on.
- R7: A B-device waiting after its request takes the host role when it sees line_conn_i. It raises drive_reset_o for exactly the first host cycle. While it is host, neither pull-up is driven.
- R8: If a B-device waiting after its request sees line_resume_i instead, it stays peripheral and drives its D+ pull-up again.
- R9: A B-device host that sees host_done_i gives the role back: the role flag goes low and dp_pu_o goes high.
- R10: An A-device (a_role_i = 1) in the unattached state turns on VBUS when sess_req_i is high. Once the level reads 3 and line_conn_i is seen, it becomes host and raises drive_reset_o for one cycle.
- R11: An A-device host sees line_disconnect while suspended, with hnp_en_i and full_speed_i high. If a_grant_i is high it becomes peripheral with dp_pu_o high. If a_grant_i is low it raises drive_resume_o for one cycle and stays host.
- R12: An A-device peripheral releases dp_pu_o after 3 ms of idle, with VBUS still on. From there, line_conn_i makes it host with a one-cycle drive_reset_o, and end_sess_i instead turns VBUS off and returns it to unattached.
- R13: A fall of the session level to 0 from any other level returns the controller to unattached within two clocks of the pin change, with all role outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_role_i | input | 1 | 1 = A-device side, 0 = B-device side |
| sess_req_i | input | 1 | A side: start a session (power VBUS) |
| end_sess_i | input | 1 | A side: end the session while waiting for connect |
| line_idle_i | input | 1 | Line is in the idle state |
| line_disc_i | input | 1 | Disconnect seen on the line |
| line_conn_i | input | 1 | Connect seen on the line |
| line_resume_i | input | 1 | Resume signaling seen on the line |
| hnp_en_i | input | 1 | Host negotiation enabled by the A-device |
| full_speed_i | input | 1 | Link runs at full speed |
| b_req_host_i | input | 1 | B side: local request for the host role |
| a_grant_i | input | 1 | A side: allow the B-device to become host |
| host_done_i | input | 1 | B side: host work finished, bus quiet |
| cmp_sel_i | input | 1 | Comparator encoding select |
| cmp_pins_i | input | 3 | External VBUS comparator pins |
| dp_pu_o | output | 1 | D+ pull-up enable |
| dm_pu_o | output | 1 | D- pull-up enable |
| drive_reset_o | output | 1 | Request to drive bus reset |
| drive_resume_o | output | 1 | Request to drive resume signaling |
| vbus_en_o | output | 1 | VBUS supply enable |
| is_host_o | output | 1 | 1 = host role, 0 = peripheral |
| suspend_o | output | 1 | Idle long enough to count as suspend |
| sess_level_o | output | 2 | Decoded session level 0..3 |
| cmp_err_o | output | 1 | Undefined comparator pattern |

## Verification
The bench samples suspend one clock before and exactly at the idle limit, and breaks the idle run part way through. A timer that is off by one, or that only pauses on a break, would flag suspend early or late. It asks for the host role while not suspended and while negotiation is disabled, then lets the far side answer with resume. A controller with a missing guard, or with no path back from the fallback, would leave its pull-ups released. It drives every comparator pattern under both encodings, including an undefined three-pin pattern, and drops VBUS while the device is host. A decoder that updates on a bad pattern, or a controller that ignores the drop, would show a wrong level or keep its role.

// File: rtl/otg_pkg.sv
package otg_pkg;
  typedef enum logic [1:0] {
    LVL_BELOW_END  = 2'd0,
    LVL_END_VALID  = 2'd1,
    LVL_VALID_VBUS = 2'd2,
    LVL_ABOVE_VBUS = 2'd3
  } sess_lvl_e;

  typedef enum logic [3:0] {
    ST_UNATT,
    ST_A_WAIT_VLD,
    ST_A_RESET,
    ST_A_HOST,
    ST_A_SUSP,
    ST_A_RESUME,
    ST_A_PERIPH,
    ST_A_WAIT_CONN,
    ST_B_PERIPH,
    ST_B_SUSP,
    ST_B_WAIT_CONN,
    ST_B_RESET,
    ST_B_HOST
  } role_st_e;

  typedef struct packed {
    logic dp_pu;
    logic dm_pu;
    logic drv_reset;
    logic drv_resume;
    logic vbus_en;
    logic host;
  } role_out_t;
endpackage

// File: rtl/otg_vbus_decode.sv
module otg_vbus_decode
  import otg_pkg::*;
#(
  parameter int PIN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic [PIN_W-1:0] pins_i,
  output sess_lvl_e        level_o,
  output logic             drop_o,
  output logic             err_o
);
  sess_lvl_e lvl_d, lvl_q;
  logic      bad_d, err_q, drop_q;

  always_comb begin
    lvl_d = lvl_q;
    bad_d = 1'b0;
    if (!sel_i) begin
      unique case (pins_i[1:0])
        2'b00: lvl_d = LVL_BELOW_END;
        2'b10: lvl_d = LVL_END_VALID;
        2'b01: lvl_d = LVL_VALID_VBUS;
        default: lvl_d = LVL_ABOVE_VBUS;
      endcase
    end else begin
      case (pins_i[2:0])
        3'b001:  lvl_d = LVL_BELOW_END;
        3'b000:  lvl_d = LVL_END_VALID;
        3'b010:  lvl_d = LVL_VALID_VBUS;
        3'b110:  lvl_d = LVL_ABOVE_VBUS;
        default: bad_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= LVL_BELOW_END;
      err_q  <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      err_q  <= bad_d;
      drop_q <= (lvl_q != LVL_BELOW_END) && (lvl_d == LVL_BELOW_END);
    end
  end

  assign level_o = lvl_q;
  assign err_o   = err_q;
  assign drop_o  = drop_q;

  AST_ERR_HOLDS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (lvl_q == $past(lvl_q))); // R3
  AST_DROP_IS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_q |-> (lvl_q == LVL_BELOW_END)); // R13
endmodule

// File: rtl/otg_idle_timer.sv
module otg_idle_timer #(
  parameter int CLK_PER_MS = 48000,
  parameter int IDLE_MS    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  output logic susp_o
);
  localparam int LIMIT = CLK_PER_MS * IDLE_MS;
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!idle_i)      cnt_q <= '0;
    else if (cnt_q != LIM_V) cnt_q <= cnt_q + 1'b1;
  end

  assign susp_o = (cnt_q == LIM_V);

  AST_SUSP_NEEDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_o |-> $past(idle_i)); // R4
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM_V); // R4
endmodule

// File: rtl/otg_role_fsm.sv
module otg_role_fsm
  import otg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      a_role_i,
  input  logic      sess_req_i,
  input  logic      end_sess_i,
  input  logic      line_idle_i,
  input  logic      line_disc_i,
  input  logic      line_conn_i,
  input  logic      line_resume_i,
  input  logic      hnp_en_i,
  input  logic      full_speed_i,
  input  logic      b_req_host_i,
  input  logic      a_grant_i,
  input  logic      host_done_i,
  input  logic      susp_i,
  input  sess_lvl_e level_i,
  input  logic      drop_i,
  output role_out_t out_o
);
  role_st_e st_q, st_d;
  logic     hnp_ok;

  assign hnp_ok = hnp_en_i && full_speed_i;

  always_comb begin
    st_d = st_q;
    if (drop_i) begin
      st_d = ST_UNATT;
    end else begin
      unique case (st_q)
        ST_UNATT: begin
          if (a_role_i && sess_req_i) st_d = ST_A_WAIT_VLD;
          else if (!a_role_i && (level_i >= LVL_VALID_VBUS)) st_d = ST_B_PERIPH;
        end
        ST_A_WAIT_VLD:
          if ((level_i == LVL_ABOVE_VBUS) && line_conn_i) st_d = ST_A_RESET;
        ST_A_RESET:  st_d = ST_A_HOST;
        ST_A_HOST:   if (susp_i) st_d = ST_A_SUSP;
        ST_A_SUSP: begin
          if (line_disc_i) begin
            if (hnp_ok && a_grant_i) st_d = ST_A_PERIPH;
            else if (hnp_ok)         st_d = ST_A_RESUME;
            else                     st_d = ST_A_WAIT_CONN;
          end else if (!susp_i) begin
            st_d = ST_A_HOST;
          end
        end
        ST_A_RESUME: st_d = ST_A_HOST;
        ST_A_PERIPH: if (susp_i) st_d = ST_A_WAIT_CONN;
        ST_A_WAIT_CONN: begin
          if (end_sess_i)       st_d = ST_UNATT;
          else if (line_conn_i) st_d = ST_A_RESET;
        end
        ST_B_PERIPH: if (susp_i) st_d = ST_B_SUSP;
        ST_B_SUSP: begin
          if (b_req_host_i && hnp_ok) st_d = ST_B_WAIT_CONN;
          else if (!susp_i)           st_d = ST_B_PERIPH;
        end
        ST_B_WAIT_CONN: begin
          if (line_conn_i)        st_d = ST_B_RESET;
          else if (line_resume_i) st_d = ST_B_PERIPH;
        end
        ST_B_RESET: st_d = ST_B_HOST;
        ST_B_HOST:  if (host_done_i) st_d = ST_B_PERIPH;
        default:    st_d = ST_UNATT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_UNATT;
    else         st_q <= st_d;
  end

  always_comb begin
    out_o = '0;
    unique case (st_q)
      ST_A_WAIT_VLD, ST_A_WAIT_CONN: out_o.vbus_en = 1'b1;
      ST_A_RESET: begin
        out_o.vbus_en = 1'b1; out_o.host = 1'b1; out_o.drv_reset = 1'b1;
      end
      ST_A_HOST, ST_A_SUSP: begin
        out_o.vbus_en = 1'b1; out_o.host = 1'b1;
      end
      ST_A_RESUME: begin
        out_o.vbus_en = 1'b1; out_o.host = 1'b1; out_o.drv_resume = 1'b1;
      end
      ST_A_PERIPH: begin
        out_o.vbus_en = 1'b1; out_o.dp_pu = 1'b1;
      end
      ST_B_PERIPH, ST_B_SUSP: begin
        out_o.dp_pu = full_speed_i;
        out_o.dm_pu = !full_speed_i;
      end
      ST_B_RESET: begin
        out_o.host = 1'b1; out_o.drv_reset = 1'b1;
      end
      ST_B_HOST: out_o.host = 1'b1;
      default: out_o = '0;
    endcase
  end

  AST_HOST_NO_PULLUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_o.host |-> !(out_o.dp_pu || out_o.dm_pu)); // R7
  AST_RESET_ON_TAKEOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_o.host) |-> out_o.drv_reset); // R10
  AST_DROP_TO_UNATT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> (st_q == ST_UNATT)); // R13
  AST_B_REQ_GUARDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_B_WAIT_CONN && $past(st_q) == ST_B_SUSP) |-> $past(hnp_ok && b_req_host_i)); // R6
  AST_RESUME_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_o.drv_resume |=> !out_o.drv_resume); // R11
endmodule

// File: rtl/otg_role_swap.sv
module otg_role_swap
  import otg_pkg::*;
#(
  parameter int CLK_PER_MS = 48000,
  parameter int IDLE_MS    = 3,
  parameter int PIN_W      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_role_i,
  input  logic             sess_req_i,
  input  logic             end_sess_i,
  input  logic             line_idle_i,
  input  logic             line_disc_i,
  input  logic             line_conn_i,
  input  logic             line_resume_i,
  input  logic             hnp_en_i,
  input  logic             full_speed_i,
  input  logic             b_req_host_i,
  input  logic             a_grant_i,
  input  logic             host_done_i,
  input  logic             cmp_sel_i,
  input  logic [PIN_W-1:0] cmp_pins_i,
  output logic             dp_pu_o,
  output logic             dm_pu_o,
  output logic             drive_reset_o,
  output logic             drive_resume_o,
  output logic             vbus_en_o,
  output logic             is_host_o,
  output logic             suspend_o,
  output logic [1:0]       sess_level_o,
  output logic             cmp_err_o
);
  sess_lvl_e level;
  logic      drop, susp;
  role_out_t ro;

  otg_vbus_decode #(.PIN_W(PIN_W)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(cmp_sel_i), .pins_i(cmp_pins_i),
    .level_o(level), .drop_o(drop), .err_o(cmp_err_o)
  );

  otg_idle_timer #(.CLK_PER_MS(CLK_PER_MS), .IDLE_MS(IDLE_MS)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .idle_i(line_idle_i), .susp_o(susp)
  );

  otg_role_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_role_i(a_role_i),
    .sess_req_i(sess_req_i), .end_sess_i(end_sess_i),
    .line_idle_i(line_idle_i), .line_disc_i(line_disc_i),
    .line_conn_i(line_conn_i), .line_resume_i(line_resume_i),
    .hnp_en_i(hnp_en_i), .full_speed_i(full_speed_i),
    .b_req_host_i(b_req_host_i), .a_grant_i(a_grant_i),
    .host_done_i(host_done_i), .susp_i(susp), .level_i(level),
    .drop_i(drop), .out_o(ro)
  );

  assign dp_pu_o        = ro.dp_pu;
  assign dm_pu_o        = ro.dm_pu;
  assign drive_reset_o  = ro.drv_reset;
  assign drive_resume_o = ro.drv_resume;
  assign vbus_en_o      = ro.vbus_en;
  assign is_host_o      = ro.host;
  assign suspend_o      = susp;
  assign sess_level_o   = level;

  AST_RESET_REQ_IS_HOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_reset_o |-> is_host_o); // R7
  AST_RESET_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_reset_o |=> !drive_reset_o); // R10
endmodule

// File: tb/otg_role_swap_bench.sv
module otg_role_swap_bench;
  localparam int CPM  = 4;
  localparam int IDLE = 3 * CPM;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic a_role, sess_req, end_sess, l_idle, l_disc, l_conn, l_res;
  logic hnp, fs, b_req, grant, done, sel;
  logic [2:0] pins;
  logic dp, dm, drst, dres, vbus, host, susp, err;
  logic [1:0] lvl;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  otg_role_swap #(.CLK_PER_MS(CPM)) u_otg_role_swap (
    .clk_i(clk), .rst_ni(rst_ni), .a_role_i(a_role), .sess_req_i(sess_req),
    .end_sess_i(end_sess), .line_idle_i(l_idle), .line_disc_i(l_disc),
    .line_conn_i(l_conn), .line_resume_i(l_res), .hnp_en_i(hnp),
    .full_speed_i(fs), .b_req_host_i(b_req), .a_grant_i(grant),
    .host_done_i(done), .cmp_sel_i(sel), .cmp_pins_i(pins),
    .dp_pu_o(dp), .dm_pu_o(dm), .drive_reset_o(drst), .drive_resume_o(dres),
    .vbus_en_o(vbus), .is_host_o(host), .suspend_o(susp),
    .sess_level_o(lvl), .cmp_err_o(err)
  );

  // {dp, dm, reset, resume, vbus, host}
  function automatic logic [5:0] outs();
    return {dp, dm, drst, dres, vbus, host};
  endfunction

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    a_role = 0; sess_req = 0; end_sess = 0; l_idle = 0; l_disc = 0;
    l_conn = 0; l_res = 0; hnp = 0; fs = 0; b_req = 0; grant = 0;
    done = 0; sel = 0; pins = 3'b000;
  endtask

  task automatic do_reset();
    clear_in();
    rst_ni = 0;
    step(2);
    rst_ni = 1;
    step();
  endtask

  task automatic t_reset();
    clear_in();
    rst_ni = 0;
    step(2);
    chk("R1 outputs in reset", {2'b0, outs()}, 8'h00);
    chk("R1 suspend/level/err in reset", {5'b0, susp, lvl}, {5'b0, err, 2'b00});
    rst_ni = 1;
    step();
    chk("R1 outputs after reset", {susp, err, outs()}, 8'h00);
  endtask

  task automatic t_sel0();
    do_reset();
    a_role = 1;
    sel = 0;
    pins = 3'b010; step(); chk("R2 pins 10 -> 1", lvl, 1);
    pins = 3'b001; step(); chk("R2 pins 01 -> 2", lvl, 2);
    pins = 3'b011; step(); chk("R2 pins 11 -> 3", lvl, 3);
    pins = 3'b000; step(); chk("R2 pins 00 -> 0", lvl, 0);
  endtask

  task automatic t_sel1();
    do_reset();
    a_role = 1;
    sel = 1;
    pins = 3'b000; step(); chk("R3 000 -> 1", lvl, 1);
    pins = 3'b010; step(); chk("R3 010 -> 2", lvl, 2);
    pins = 3'b110; step(); chk("R3 110 -> 3", lvl, 3);
    pins = 3'b111; step(); chk("R3 111 holds level", lvl, 3);
    chk("R3 111 raises error", err, 1);
    pins = 3'b100; step(); chk("R3 100 still holds", {err, lvl}, {1'b1, 2'd3});
    pins = 3'b010; step(); chk("R3 valid pattern clears error", {err, lvl}, {1'b0, 2'd2});
    pins = 3'b001; step(); chk("R3 001 -> 0", lvl, 0);
  endtask

  task automatic t_timer();
    do_reset();
    l_idle = 1;
    step(IDLE - 1); chk("R4 suspend one clock early", susp, 0);
    step();         chk("R4 suspend at limit", susp, 1);
    l_idle = 0; step(); chk("R4 activity clears suspend", susp, 0);
    l_idle = 1; step(6);
    l_idle = 0; step();
    l_idle = 1; step(IDLE - 1); chk("R4 count restarted after break", susp, 0);
    step(); chk("R4 suspend after full restart", susp, 1);
  endtask

  task automatic b_to_periph();
    do_reset();
    a_role = 0; fs = 1; hnp = 1; sel = 0;
    pins = 3'b001;
    step(2);
  endtask

  task automatic b_to_wait();
    b_to_periph();
    l_idle = 1;
    step(IDLE + 1);
    b_req = 1;
    step();
  endtask

  task automatic t_b_start();
    do_reset();
    a_role = 0; fs = 1; sel = 0;
    pins = 3'b010; step(3);
    chk("R5 level 1 does not start B session", {2'b0, outs()}, 8'h00);
    pins = 3'b001; step(2);
    chk("R5 B peripheral full speed", {2'b0, outs()}, 8'b00100000);
    fs = 0; step();
    chk("R5 B peripheral low speed", {2'b0, outs()}, 8'b00010000);
  endtask

  task automatic t_b_guard();
    b_to_periph();
    l_idle = 1; step(5);
    b_req = 1; step();
    chk("R6 request before suspend ignored", {2'b0, outs()}, 8'b00100000);
    b_req = 0; hnp = 0;
    step(IDLE + 1);
    b_req = 1; step();
    chk("R6 request without negotiation enable ignored", {2'b0, outs()}, 8'b00100000);
    b_req = 0; hnp = 1; fs = 1;
  endtask

  task automatic t_b_swap();
    b_to_wait();
    chk("R6 request releases both pull-ups", {2'b0, outs()}, 8'h00);
    b_req = 0; l_idle = 0; l_conn = 1; step();
    chk("R7 B first host cycle drives reset", {2'b0, outs()}, 8'b00001001);
    l_conn = 0; step();
    chk("R7 B host after reset cycle", {2'b0, outs()}, 8'b00000001);
    done = 1; step();
    chk("R9 B hands host role back", {2'b0, outs()}, 8'b00100000);
    done = 0;
  endtask

  task automatic t_b_resume();
    b_to_wait();
    b_req = 0; l_idle = 0; l_res = 1; step();
    chk("R8 resume answer restores D+ pull-up", {2'b0, outs()}, 8'b00100000);
    l_res = 0;
  endtask

  task automatic a_to_host();
    do_reset();
    a_role = 1; sel = 0; hnp = 1; fs = 1;
    sess_req = 1; step();
    chk("R10 session request powers VBUS", {2'b0, outs()}, 8'b00000010);
    sess_req = 0;
    pins = 3'b011; l_conn = 1; step(2);
    chk("R10 A first host cycle drives reset", {2'b0, outs()}, 8'b00001011);
    l_conn = 0; step();
    chk("R10 A host", {2'b0, outs()}, 8'b00000011);
  endtask

  task automatic t_a_grant();
    a_to_host();
    l_idle = 1; step(IDLE + 1);
    l_idle = 0; l_disc = 1; grant = 1; step();
    chk("R11 granted swap enables D+ pull-up", {2'b0, outs()}, 8'b00100010);
    l_disc = 0; grant = 0; l_idle = 1; step(IDLE);
    chk("R12 still peripheral at idle limit", {2'b0, outs()}, 8'b00100010);
    step();
    chk("R12 D+ released after suspend, VBUS on", {2'b0, outs()}, 8'b00000010);
    l_idle = 0; l_conn = 1; step();
    chk("R12 connect takes host with reset", {2'b0, outs()}, 8'b00001011);
    l_conn = 0;
  endtask

  task automatic t_a_refuse();
    a_to_host();
    l_idle = 1; step(IDLE + 1);
    l_idle = 0; l_disc = 1; grant = 0; step();
    chk("R11 refused swap drives resume", {2'b0, outs()}, 8'b00000111);
    l_disc = 0; step();
    chk("R11 stays host after resume", {2'b0, outs()}, 8'b00000011);
  endtask

  task automatic t_a_end();
    a_to_host();
    l_idle = 1; step(IDLE + 1);
    l_idle = 0; l_disc = 1; grant = 1; step();
    l_disc = 0; grant = 0; l_idle = 1; step(IDLE + 1);
    end_sess = 1; step();
    chk("R12 end of session turns VBUS off", {2'b0, outs()}, 8'h00);
    end_sess = 0;
  endtask

  task automatic t_drop();
    b_to_wait();
    b_req = 0; l_idle = 0; l_conn = 1; step(2);
    l_conn = 0;
    pins = 3'b000; step(2);
    chk("R13 B host drops to unattached", {2'b0, outs()}, 8'h00);
    a_to_host();
    pins = 3'b000; step(2);
    chk("R13 A host drops to unattached", {2'b0, outs()}, 8'h00);
  endtask

  initial begin
    clear_in();
    t_reset();
    t_sel0();
    t_sel1();
    t_timer();
    t_b_start();
    t_b_guard();
    t_b_swap();
    t_b_resume();
    t_a_grant();
    t_a_refuse();
    t_a_end();
    t_drop();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule